// File: doc/BRIEF.md
# Stall-Time Fair DRAM Request Scheduler

This block chooses one request per cycle from a shared DRAM request buffer. Several hardware threads fill that buffer. For each thread the block keeps a count of the cycles the thread has spent stalled on memory while sharing the system. It also receives an outside estimate of how long that thread would have stalled if it ran alone. The ratio of the two is the thread's memory slowdown. The ratio of the largest slowdown to the smallest, taken over threads that have a request waiting, measures how unfair the system currently is.

While that unfairness stays under a programmable threshold, the block schedules for DRAM throughput: row-buffer hits go first, then older requests. Once the unfairness reaches the threshold, the block first promotes every request of the most slowed-down thread, even ahead of row hits. The grant is combinational. It is worked out from the present buffer contents and from the stall counters as they were registered at the last clock edge, so the memory controller can issue the chosen entry in the same cycle.

Top module: `stfm_sched`

## Requirements
- R1: A thread's shared stall counter goes up by one at each clock edge where that thread's stall strobe is high. A strobe seen in cycle n first changes the grant in cycle n+1. All counters are zero after reset.
- R2: A stall counter holds at its all-ones value once it reaches it and does not wrap.
- R3: An alone-stall estimate of zero is used as one when slowdowns are compared.
- R4: Only threads that own at least one valid buffer entry take part in choosing the largest and smallest slowdown.
- R5: In throughput mode the grant goes to a row hit before a row miss, then to the larger age value (larger means older), then to the lower entry index. A request is a row hit when its row equals the open row of the bank it addresses.
- R6: Fairness mode applies when max slowdown / min slowdown ≥ threshold / 16, with the threshold read as unsigned and having 4 fractional bits. In fairness mode, requests from the thread with the largest slowdown come first (the lower thread index wins a tie), then row hits, then age, then the lower entry index.
- R7: With fewer than two threads pending, throughput mode is used. When every pending thread has zero slowdown, unfairness counts as exactly one.
- R8: With no valid entry, grant_valid is low and grant_idx is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_ENTRIES | Entry holds a pending request |
| req_tid | input | NUM_ENTRIES*TID_W | Owning thread of each entry |
| req_bank | input | NUM_ENTRIES*BANK_W | Target bank of each entry |
| req_row | input | NUM_ENTRIES*ROW_W | Target row of each entry |
| req_age | input | NUM_ENTRIES*AGE_W | Age of each entry, larger is older |
| open_row | input | NUM_BANKS*ROW_W | Row currently open in each bank |
| stall_strobe | input | NUM_THREADS | Thread is stalled on memory this cycle |
| alone_est | input | NUM_THREADS*EST_W | Estimated alone stall time per thread |
| unfair_thresh | input | THR_W | Unfairness threshold, 4 fractional bits |
| grant_valid | output | 1 | A request is granted this cycle |
| grant_idx | output | IDX_W | Buffer index of the granted entry |

## Verification
Two situations are hard to reach from the ports. The first is the exact boundary where the unfairness equals the threshold. The second is a stall counter pinned at saturation. Neither can be seen directly, because the only thing visible is which entry wins. The stimulus therefore builds counter values by holding strobes for chosen numbers of cycles. It then places a row-hit request from one thread against a row-miss request from another, so the winner shows which mode was taken and which thread was favoured. A narrowed counter width lets saturation be reached within a few hundred cycles. Seeded random buffers, strobes, estimates and thresholds then run against a bench-side model.

// File: rtl/stfm_pkg.sv
package stfm_pkg;
    localparam int DEF_ENTRIES = 16;
    localparam int DEF_THREADS = 4;
    localparam int DEF_BANKS   = 8;
    localparam int DEF_ROW_W   = 14;
    localparam int DEF_AGE_W   = 8;
    localparam int DEF_STALL_W = 16;
    localparam int DEF_EST_W   = 16;
    localparam int DEF_THR_W   = 8;
    localparam int THR_FRAC    = 4;

    typedef enum logic {
        MODE_THRU = 1'b0,
        MODE_FAIR = 1'b1
    } sched_mode_e;
endpackage

// File: rtl/stfm_stall_ctr.sv
module stfm_stall_ctr #(
    parameter int STALL_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    output logic [STALL_W-1:0] count
);
    localparam logic [STALL_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [STALL_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + STALL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    // R1
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && count != CNT_MAX) |=> (count == $past(count) + STALL_W'(1)));
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(count));
    // R2
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX));
endmodule

// File: rtl/stfm_fairness.sv
module stfm_fairness import stfm_pkg::*; #(
    parameter int NUM_THREADS = DEF_THREADS,
    parameter int STALL_W     = DEF_STALL_W,
    parameter int EST_W       = DEF_EST_W,
    parameter int THR_W       = DEF_THR_W,
    parameter int TID_W       = $clog2(NUM_THREADS)
) (
    input  logic [NUM_THREADS*STALL_W-1:0] stall_cnt,
    input  logic [NUM_THREADS*EST_W-1:0]   alone_est,
    input  logic [NUM_THREADS-1:0]         thread_pend,
    input  logic [THR_W-1:0]               unfair_thresh,
    output sched_mode_e                    mode,
    output logic [TID_W-1:0]               fav_tid
);
    localparam int CMP_W = STALL_W + EST_W + THR_W + THR_FRAC;
    localparam int CNT_W = $clog2(NUM_THREADS + 1);

    logic [CMP_W-1:0] s_ext [NUM_THREADS];
    logic [CMP_W-1:0] a_ext [NUM_THREADS];
    logic [TID_W-1:0] hi, lo;
    logic [CNT_W-1:0] npend;
    logic             seen;
    logic [CMP_W-1:0] lhs, rhs;
    logic             over;

    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            s_ext[t] = CMP_W'(stall_cnt[t*STALL_W +: STALL_W]);
            a_ext[t] = (alone_est[t*EST_W +: EST_W] == '0) ? CMP_W'(1)
                                                           : CMP_W'(alone_est[t*EST_W +: EST_W]);
        end
    end

    always_comb begin
        hi    = '0;
        lo    = '0;
        seen  = 1'b0;
        npend = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (thread_pend[t]) begin
                npend = npend + CNT_W'(1);
                if (!seen) begin
                    hi   = TID_W'(t);
                    lo   = TID_W'(t);
                    seen = 1'b1;
                end else begin
                    if (s_ext[t] * a_ext[hi] > s_ext[hi] * a_ext[t]) hi = TID_W'(t);
                    if (s_ext[t] * a_ext[lo] < s_ext[lo] * a_ext[t]) lo = TID_W'(t);
                end
            end
        end
        lhs = (s_ext[hi] * a_ext[lo]) << THR_FRAC;
        rhs = CMP_W'(unfair_thresh) * s_ext[lo] * a_ext[hi];
        if (s_ext[hi] == '0) begin
            over = (CMP_W'(1) << THR_FRAC) >= CMP_W'(unfair_thresh);
        end else begin
            over = lhs >= rhs;
        end
        mode    = (npend >= CNT_W'(2) && over) ? MODE_FAIR : MODE_THRU;
        fav_tid = hi;
    end
endmodule

// File: rtl/stfm_picker.sv
module stfm_picker import stfm_pkg::*; #(
    parameter int NUM_ENTRIES = DEF_ENTRIES,
    parameter int NUM_BANKS   = DEF_BANKS,
    parameter int ROW_W       = DEF_ROW_W,
    parameter int AGE_W       = DEF_AGE_W,
    parameter int TID_W       = 2,
    parameter int BANK_W      = $clog2(NUM_BANKS),
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0]        req_valid,
    input  logic [NUM_ENTRIES*TID_W-1:0]  req_tid,
    input  logic [NUM_ENTRIES*BANK_W-1:0] req_bank,
    input  logic [NUM_ENTRIES*ROW_W-1:0]  req_row,
    input  logic [NUM_ENTRIES*AGE_W-1:0]  req_age,
    input  logic [NUM_BANKS*ROW_W-1:0]    open_row,
    input  sched_mode_e                   mode,
    input  logic [TID_W-1:0]              fav_tid,
    output logic                          grant_valid,
    output logic [IDX_W-1:0]              grant_idx
);
    localparam int KEY_W = AGE_W + 2;

    logic [KEY_W-1:0] best;

    always_comb begin
        best        = '0;
        grant_idx   = '0;
        grant_valid = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            logic [BANK_W-1:0] bk;
            logic              hit;
            logic              fav;
            logic [KEY_W-1:0]  key;
            bk  = req_bank[i*BANK_W +: BANK_W];
            hit = req_row[i*ROW_W +: ROW_W] == open_row[int'(bk)*ROW_W +: ROW_W];
            fav = (mode == MODE_FAIR) && (req_tid[i*TID_W +: TID_W] == fav_tid);
            key = {fav, hit, req_age[i*AGE_W +: AGE_W]};
            if (req_valid[i] && (!grant_valid || key > best)) begin
                best        = key;
                grant_idx   = IDX_W'(i);
                grant_valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/stfm_sched.sv
module stfm_sched import stfm_pkg::*; #(
    parameter int NUM_ENTRIES = DEF_ENTRIES,
    parameter int NUM_THREADS = DEF_THREADS,
    parameter int NUM_BANKS   = DEF_BANKS,
    parameter int ROW_W       = DEF_ROW_W,
    parameter int AGE_W       = DEF_AGE_W,
    parameter int STALL_W     = DEF_STALL_W,
    parameter int EST_W       = DEF_EST_W,
    parameter int THR_W       = DEF_THR_W,
    localparam int TID_W      = $clog2(NUM_THREADS),
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_ENTRIES-1:0]        req_valid,
    input  logic [NUM_ENTRIES*TID_W-1:0]  req_tid,
    input  logic [NUM_ENTRIES*BANK_W-1:0] req_bank,
    input  logic [NUM_ENTRIES*ROW_W-1:0]  req_row,
    input  logic [NUM_ENTRIES*AGE_W-1:0]  req_age,
    input  logic [NUM_BANKS*ROW_W-1:0]    open_row,
    input  logic [NUM_THREADS-1:0]        stall_strobe,
    input  logic [NUM_THREADS*EST_W-1:0]  alone_est,
    input  logic [THR_W-1:0]              unfair_thresh,
    output logic                          grant_valid,
    output logic [IDX_W-1:0]              grant_idx
);
    logic [NUM_THREADS*STALL_W-1:0] stall_cnt;
    logic [NUM_THREADS-1:0]         thread_pend;
    sched_mode_e                    mode;
    logic [TID_W-1:0]               fav_tid;
    logic [TID_W-1:0]               gnt_tid;

    always_comb begin
        thread_pend = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (req_valid[i]) begin
                thread_pend[req_tid[i*TID_W +: TID_W]] = 1'b1;
            end
        end
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_ctr
        stfm_stall_ctr #(.STALL_W(STALL_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (stall_strobe[t]),
            .count  (stall_cnt[t*STALL_W +: STALL_W])
        );
    end

    stfm_fairness #(
        .NUM_THREADS (NUM_THREADS),
        .STALL_W     (STALL_W),
        .EST_W       (EST_W),
        .THR_W       (THR_W),
        .TID_W       (TID_W)
    ) u_fair (
        .stall_cnt     (stall_cnt),
        .alone_est     (alone_est),
        .thread_pend   (thread_pend),
        .unfair_thresh (unfair_thresh),
        .mode          (mode),
        .fav_tid       (fav_tid)
    );

    stfm_picker #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .NUM_BANKS   (NUM_BANKS),
        .ROW_W       (ROW_W),
        .AGE_W       (AGE_W),
        .TID_W       (TID_W),
        .BANK_W      (BANK_W),
        .IDX_W       (IDX_W)
    ) u_pick (
        .req_valid   (req_valid),
        .req_tid     (req_tid),
        .req_bank    (req_bank),
        .req_row     (req_row),
        .req_age     (req_age),
        .open_row    (open_row),
        .mode        (mode),
        .fav_tid     (fav_tid),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    assign gnt_tid = req_tid[int'(grant_idx)*TID_W +: TID_W];

    // R8
    idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_valid) |-> !grant_valid);
    // R5
    grant_entry_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> req_valid[grant_idx]);
    // R7
    fair_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAIR) |-> ($countones(thread_pend) >= 2));
    // R4
    fav_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAIR) |-> thread_pend[fav_tid]);
    // R6
    fav_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAIR) |-> (grant_valid && gnt_tid == fav_tid));
endmodule

// File: tb/tb_stfm_sched.sv
`timescale 1ns/1ps
module tb_stfm_sched;
    localparam int NE = 16, NT = 4, NB = 8, RW = 12, AW = 8, SW = 8, EW = 12, TW = 8;
    localparam int TIDW = 2, BKW = 3, IXW = 4;
    localparam longint SMAX = (64'd1 << SW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            v     [NE];
    logic [TIDW-1:0] tid   [NE];
    logic [BKW-1:0]  bank  [NE];
    logic [RW-1:0]   row   [NE];
    logic [AW-1:0]   age   [NE];
    logic [RW-1:0]   orow  [NB];
    logic            stb   [NT];
    logic [EW-1:0]   alone [NT];
    logic [TW-1:0]   th;
    longint          mctr  [NT];

    logic [NE-1:0]      req_valid;
    logic [NE*TIDW-1:0] req_tid;
    logic [NE*BKW-1:0]  req_bank;
    logic [NE*RW-1:0]   req_row;
    logic [NE*AW-1:0]   req_age;
    logic [NB*RW-1:0]   open_row;
    logic [NT-1:0]      stall_strobe;
    logic [NT*EW-1:0]   alone_est;
    logic               grant_valid;
    logic [IXW-1:0]     grant_idx;

    int checks = 0;
    int errors = 0;

    always_comb begin
        for (int i = 0; i < NE; i++) begin
            req_valid[i]             = v[i];
            req_tid[i*TIDW +: TIDW]  = tid[i];
            req_bank[i*BKW +: BKW]   = bank[i];
            req_row[i*RW +: RW]      = row[i];
            req_age[i*AW +: AW]      = age[i];
        end
        for (int b = 0; b < NB; b++) open_row[b*RW +: RW] = orow[b];
        for (int t = 0; t < NT; t++) begin
            stall_strobe[t]        = stb[t];
            alone_est[t*EW +: EW]  = alone[t];
        end
    end

    stfm_sched #(
        .NUM_ENTRIES(NE), .NUM_THREADS(NT), .NUM_BANKS(NB), .ROW_W(RW),
        .AGE_W(AW), .STALL_W(SW), .EST_W(EW), .THR_W(TW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
        .req_bank(req_bank), .req_row(req_row), .req_age(req_age),
        .open_row(open_row), .stall_strobe(stall_strobe), .alone_est(alone_est),
        .unfair_thresh(th), .grant_valid(grant_valid), .grant_idx(grant_idx)
    );

    function automatic void expect_grant(output bit ev, output int ei);
        longint s [NT];
        longint a [NT];
        bit     pend [NT];
        int     np = 0, hi = 0, lo = 0;
        bit     seen = 0, fair;
        int     bestk = -1;
        for (int t = 0; t < NT; t++) begin
            s[t] = mctr[t];
            a[t] = (alone[t] == 0) ? 1 : longint'(alone[t]);
            pend[t] = 0;
        end
        for (int i = 0; i < NE; i++) if (v[i]) pend[tid[i]] = 1;
        for (int t = 0; t < NT; t++) begin
            if (pend[t]) begin
                np++;
                if (!seen) begin hi = t; lo = t; seen = 1; end
                else begin
                    if (s[t] * a[hi] > s[hi] * a[t]) hi = t;
                    if (s[t] * a[lo] < s[lo] * a[t]) lo = t;
                end
            end
        end
        if (np < 2) fair = 0;
        else if (s[hi] == 0) fair = (16 >= th);
        else fair = (s[hi] * a[lo] * 16 >= longint'(th) * s[lo] * a[hi]);
        ev = 0; ei = 0;
        for (int i = 0; i < NE; i++) begin
            if (v[i]) begin
                int k;
                k = ((fair && tid[i] == hi) ? 1024 : 0) + ((row[i] == orow[bank[i]]) ? 512 : 0) + int'(age[i]);
                if (k > bestk) begin bestk = k; ev = 1; ei = i; end
            end
        end
    endfunction

    task automatic check_grant(input string rq);
        bit ev; int ei;
        expect_grant(ev, ei);
        checks++;
        if (grant_valid !== ev || int'(grant_idx) !== ei) begin
            errors++;
            $display("FAIL %s: grant_valid=%0b grant_idx=%0d expected valid=%0b idx=%0d",
                     rq, grant_valid, grant_idx, ev, ei);
        end
    endtask

    task automatic step(input bit chk, input string rq);
        #1;
        if (chk) check_grant(rq);
        for (int t = 0; t < NT; t++) if (stb[t] && mctr[t] != SMAX) mctr[t]++;
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        for (int i = 0; i < NE; i++) begin
            v[i] = 0; tid[i] = 0; bank[i] = 0; row[i] = 0; age[i] = 0;
        end
        for (int b = 0; b < NB; b++) orow[b] = 0;
        for (int t = 0; t < NT; t++) begin stb[t] = 0; alone[t] = 1; end
        th = 8'd16;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        clear_inputs();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        for (int t = 0; t < NT; t++) mctr[t] = 0;
    endtask

    task automatic run_strobes(input int t, input int n);
        stb[t] = 1;
        repeat (n) step(0, "");
        stb[t] = 0;
    endtask

    task automatic set_entry(input int i, input int tt, input int bk, input int rw, input int ag);
        v[i] = 1; tid[i] = TIDW'(tt); bank[i] = BKW'(bk); row[i] = RW'(rw); age[i] = AW'(ag);
    endtask

    // Two-entry contest: e0 is a row hit of thread h, e1 a row miss of thread m.
    task automatic hit_vs_miss(input int h, input int m);
        orow[0] = 5; orow[1] = 9;
        set_entry(0, h, 0, 5, 10);
        set_entry(1, m, 1, 3, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        clear_inputs();
        for (int t = 0; t < NT; t++) mctr[t] = 0;

        // R8: reset state and empty buffer
        do_reset();
        step(1, "R8 empty buffer");

        // R5: hit beats older miss; equal-age hits go to lower index
        orow[0] = 1; orow[1] = 7;
        set_entry(0, 0, 0, 5, 200);
        set_entry(3, 0, 1, 7, 10);
        set_entry(5, 0, 1, 7, 10);
        step(1, "R5 hit tie lower index");
        age[3] = 9;
        step(1, "R5 older hit wins");
        v[3] = 0; v[5] = 0;
        step(1, "R5 single miss");

        // R6: thread1 slowdown 5.0, thread0 0.5, unfairness 10
        do_reset();
        for (int t = 0; t < NT; t++) alone[t] = 4;
        run_strobes(1, 20);
        run_strobes(0, 2);
        hit_vs_miss(0, 1);
        th = 80;  step(1, "R6 above threshold favours slowed thread");
        th = 160; step(1, "R6 equal to threshold is fairness mode");
        th = 161; step(1, "R6 below threshold uses throughput");

        // R4: thread2 has a huge slowdown but nothing pending
        run_strobes(2, 100);
        th = 80;
        hit_vs_miss(0, 1);
        step(1, "R4 idle thread excluded");

        // R3: zero alone estimate read as one
        do_reset();
        run_strobes(0, 8);
        run_strobes(1, 8);
        alone[0] = 0; alone[1] = 2;
        th = 32;
        hit_vs_miss(1, 0);
        step(1, "R3 zero estimate as one");

        // R2: counter saturation
        do_reset();
        run_strobes(0, 300);
        run_strobes(1, 100);
        th = 16;
        hit_vs_miss(1, 0);
        step(1, "R2 saturated counter keeps lead");

        // R1: one strobe cycle changes the pick on the next cycle
        do_reset();
        th = 32;
        hit_vs_miss(1, 0);
        stb[0] = 1;
        step(1, "R1 strobe not yet counted");
        stb[0] = 0;
        step(1, "R1 strobe counted next cycle");

        // R7: all-zero slowdowns count as unfairness one
        do_reset();
        th = 16;
        hit_vs_miss(1, 0);
        step(1, "R7 zero slowdowns equal threshold one");
        th = 17;
        step(1, "R7 zero slowdowns below threshold");
        v[0] = 0;
        th = 0;
        step(1, "R7 single pending thread");

        // Random phase
        for (int n = 0; n < 2500; n++) begin
            if (n % 400 == 0) do_reset();
            for (int i = 0; i < NE; i++) begin
                v[i]    = ($urandom % 3) != 0;
                tid[i]  = TIDW'($urandom);
                bank[i] = BKW'($urandom);
                row[i]  = RW'($urandom % 4);
                age[i]  = AW'($urandom);
            end
            for (int b = 0; b < NB; b++) orow[b] = RW'($urandom % 4);
            for (int t = 0; t < NT; t++) begin
                stb[t]   = ($urandom % 3) == 0;
                alone[t] = EW'($urandom % 8);
            end
            th = TW'($urandom % 64);
            step(1, "R4 R5 R6 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule